// File: doc/BRIEF.md
# XYX Route-Computing Mesh Router

This block is one router of a two-dimensional mesh in which part of the horizontal links have been removed. It knows its own position from two coordinate pins. For every packet it picks one output: one of the four neighbour directions or the local port. Packets that must climb in Y travel along X first and then along Y. Packets that must descend in Y turn into Y straight away and travel along X only once the row is reached. Because of this rule only four of the eight possible 90-degree turns are ever taken, so no cyclic channel dependency can form and the reduced mesh stays deadlock-free.

Each present input has a four-flit FIFO. The route is worked out once per packet, from the destination fields of the head flit. Every output has a round-robin arbiter that keeps its grant until the tail flit of the winning packet has left. A crossbar moves the granted flits. An input whose link does not exist, as chosen by a mask parameter, has no FIFO and is left out of the arbiters and the crossbar.

Every flit interface is valid/ready. A flit moves on a clock edge where valid and ready are both high. Once an output raises valid it holds that flit, unchanged, until ready is seen. Input ready depends only on FIFO occupancy and never on the input valid.

Top module: `xyx_router`

## Requirements
- R1: Port indices are 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-. An input index names the direction its flits are already travelling. With dx = dest_x - cur_x and dy = dest_y - cur_y taken as signed values, a head flit with dy >= 0 and dx > 0 leaves on X+ (1).
- R2: A head flit with dy >= 0 and dx < 0 leaves on X- (2).
- R3: A head flit with dx = 0 leaves on the local port (0) when dy = 0 and on Y+ (3) when dy > 0.
- R4: A head flit with dy < 0 leaves on Y- (4), whatever dx is.
- R5: With legal traffic no forbidden turn is granted. Flits on X+ never go to X- or Y-. Flits on X- never go to X+ or Y-. Flits on Y+ never go to X+, X- or Y-. Flits on Y- never go to Y+.
- R6: An input cleared in parameter IN_MASK (bit = port index) keeps its ready low, and nothing it drives ever reaches an output.
- R7: Body and tail flits take the output chosen for their head flit, and their own destination fields are ignored. The output is released when the tail flit moves.
- R8: When several inputs want one free output, the first requester at or after a rotating pointer wins. The pointer moves to winner+1 (mod 5) when a head flit moves. The grant stays with the winner until its tail flit has moved.
- R9: Flit format, MSB first: head bit, tail bit, dest_x (CW bits), dest_y (CW bits), payload (PW bits). Input ready is low exactly when that input's FIFO holds 4 flits. While an output has valid high and ready low, its valid and data stay unchanged.
- R10: After reset all outputs are invalid and every present input is ready. A flit accepted on an edge is offered at an idle output right after that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_x | input | CW | X coordinate of this router |
| cur_y | input | CW | Y coordinate of this router |
| in_valid | input | 5 | Input flit valid, one bit per port index |
| in_ready | output | 5 | Input can accept a flit, one bit per port index |
| in_data | input | 5*FW | Input flits, port p at bits [p*FW +: FW] |
| out_valid | output | 5 | Output flit valid, one bit per port index |
| out_ready | input | 5 | Downstream accepts, one bit per port index |
| out_data | output | 5*FW | Output flits, port p at bits [p*FW +: FW] |

## Verification
A flit accepted on a rising edge sits in its FIFO right after that edge, so the directed checks look for it at the chosen output at the next falling edge plus a small delay. In-ready and output data are looked at in the same window. A behavioural model of queues and per-output lock and pointer state is advanced on every rising edge from the same handshakes the design sees. Its expected valid, data and ready values are compared with the design at every falling edge, so a grant, a stall or a pointer move that comes one cycle early or late is seen in the cycle it happens.

// File: rtl/xyx_pkg.sv
package xyx_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    P_LOC = 3'd0,
    P_XP  = 3'd1,
    P_XM  = 3'd2,
    P_YP  = 3'd3,
    P_YM  = 3'd4
  } port_e;

  // outputs a flit travelling on input 'inp' may never be sent to
  function automatic logic [NPORT-1:0] forbidden_outs(input int inp);
    case (inp)
      1:       return 5'b10100;
      2:       return 5'b10010;
      3:       return 5'b10110;
      4:       return 5'b01000;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/xyx_fifo.sv
module xyx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rp, wp;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CNTW'(DEPTH));
  assign empty = (cnt == '0);

  // R9: the flit at the head stays put until it is popped
  a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(dout));
endmodule

// File: rtl/xyx_route.sv
module xyx_route #(
  parameter int CW = 3
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic [4:0]    sel
);
  logic signed [CW:0] xo, yo;

  always_comb begin
    xo  = $signed({1'b0, dst_x}) - $signed({1'b0, cur_x});
    yo  = $signed({1'b0, dst_y}) - $signed({1'b0, cur_y});
    sel = '0;
    if (yo < 0)       sel[4] = 1'b1;   // descend first
    else if (xo > 0)  sel[1] = 1'b1;
    else if (xo < 0)  sel[2] = 1'b1;
    else if (yo == 0) sel[0] = 1'b1;
    else              sel[3] = 1'b1;
  end
endmodule

// File: rtl/xyx_arb.sv
module xyx_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         fire,
  input  logic         fl_head,
  input  logic         fl_tail,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, owner_q, win;
  logic          lock_q;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    win   = owner_q;
    found = 1'b0;
    idx   = 0;
    if (lock_q) begin
      gnt[owner_q] = req[owner_q];
    end else begin
      for (int k = 0; k < N; k++) begin
        idx = (int'(ptr_q) + k) % N;
        if (!found && req[idx]) begin
          found    = 1'b1;
          gnt[idx] = 1'b1;
          win      = IW'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      owner_q <= '0;
      lock_q  <= 1'b0;
    end else if (|gnt) begin
      lock_q  <= !(fire && fl_tail);
      owner_q <= win;
      if (fire && fl_head) ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end

  // R8: at most one input granted
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R8: a grant that is offered but not taken is kept
  a_r8_grant_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && !fire) |=> (gnt == $past(gnt)));
endmodule

// File: rtl/xyx_router.sv
module xyx_router
  import xyx_pkg::*;
#(
  parameter int              CW      = 3,
  parameter int              PW      = 8,
  parameter int              DEPTH   = 4,
  parameter logic [NPORT-1:0] IN_MASK = 5'b11111,
  localparam int             FW      = 2 + 2 * CW + PW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       cur_x,
  input  logic [CW-1:0]       cur_y,
  input  logic [NPORT-1:0]    in_valid,
  output logic [NPORT-1:0]    in_ready,
  input  logic [NPORT*FW-1:0] in_data,
  output logic [NPORT-1:0]    out_valid,
  input  logic [NPORT-1:0]    out_ready,
  output logic [NPORT*FW-1:0] out_data
);
  localparam int HB    = FW - 1;
  localparam int TB    = FW - 2;
  localparam int DX_LO = PW + CW;
  localparam int DY_LO = PW;

  logic [FW-1:0]    fdata    [NPORT];
  logic [NPORT-1:0] fvalid;
  logic [NPORT-1:0] useroute [NPORT];
  logic [NPORT-1:0] req      [NPORT];
  logic [NPORT-1:0] gnt      [NPORT];
  logic [FW-1:0]    outd     [NPORT];
  logic [NPORT-1:0] pop;

  // ---------------- input side ----------------
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    if (IN_MASK[i]) begin : g_live
      logic             full, empty;
      logic [NPORT-1:0] rsel, held_q;

      xyx_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid[i] && !full),
        .din   (in_data[i*FW +: FW]),
        .pop   (pop[i]),
        .dout  (fdata[i]),
        .full  (full),
        .empty (empty)
      );

      xyx_route #(.CW(CW)) u_route (
        .cur_x (cur_x),
        .cur_y (cur_y),
        .dst_x (fdata[i][DX_LO +: CW]),
        .dst_y (fdata[i][DY_LO +: CW]),
        .sel   (rsel)
      );

      always_ff @(posedge clk) begin
        if (!rst_n)                     held_q <= '0;
        else if (pop[i] && fdata[i][HB]) held_q <= rsel;
      end

      assign in_ready[i] = !full;
      assign fvalid[i]   = !empty;
      assign useroute[i] = fdata[i][HB] ? rsel : held_q;

      // R5: no forbidden turn is ever taken
      a_r5_no_forbidden_turn: assert property (@(posedge clk) disable iff (!rst_n)
        pop[i] |-> ((useroute[i] & forbidden_outs(i)) == '0));
    end else begin : g_absent
      assign in_ready[i] = 1'b0;
      assign fvalid[i]   = 1'b0;
      assign fdata[i]    = '0;
      assign useroute[i] = '0;
    end
  end

  // ---------------- request matrix and pops ----------------
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = fvalid[i] && useroute[i][o];
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        if (gnt[o][i] && out_ready[o]) pop[i] = 1'b1;
  end

  // ---------------- output side ----------------
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    always_comb begin
      outd[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i]) outd[o] = outd[o] | fdata[i];
    end

    assign out_valid[o]           = |gnt[o];
    assign out_data[o*FW +: FW]   = outd[o];

    xyx_arb #(.N(NPORT)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[o]),
      .fire    (out_valid[o] && out_ready[o]),
      .fl_head (outd[o][HB]),
      .fl_tail (outd[o][TB]),
      .gnt     (gnt[o])
    );

    // R9: a stalled output keeps its flit
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(outd[o])));
  end

  // R3: head flits only reach the local port at their destination
  a_r3_local_at_home: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_LOC] && outd[P_LOC][HB]) |->
      (outd[P_LOC][DX_LO +: CW] == cur_x && outd[P_LOC][DY_LO +: CW] == cur_y));
endmodule

// File: tb/sim_xyx_router.sv
`timescale 1ns/1ps
module sim_xyx_router;
  localparam int CW = 3, PW = 8, NP = 5;
  localparam int FW = 2 + 2 * CW + PW;
  localparam logic [NP-1:0] MASK = 5'b11011;   // X- input absent
  localparam int CX = 3, CY = 4;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [NP*FW-1:0] in_data = '0, out_data;

  always #4 clk = ~clk;   // 125 MHz

  xyx_router #(.CW(CW), .PW(PW), .IN_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .cur_x(CW'(CX)), .cur_y(CW'(CY)),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int n_chk = 0, n_fail = 0;
  bit model_on = 0, gen_on = 0;
  int cycles = 0, sent = 0, recv = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(bit h, bit t, int dx, int dy, int d);
    return {h, t, CW'(dx), CW'(dy), PW'(d)};
  endfunction

  function automatic int route_of(logic [FW-1:0] f);
    int dx, dy;
    dx = int'(f[PW+CW +: CW]) - CX;
    dy = int'(f[PW +: CW]) - CY;
    if (dy < 0) return 4;
    if (dx > 0) return 1;
    if (dx < 0) return 2;
    if (dy == 0) return 0;
    return 3;
  endfunction

  // ---------------- behavioural reference ----------------
  logic [FW-1:0] mq [NP][$];
  logic [FW-1:0] pend [NP][$];
  int mheld [NP], mown [NP], mptr [NP], eg [NP];
  bit mlock [NP];

  function automatic int want(int i);
    if (mq[i].size() == 0) return -1;
    return mq[i][0][FW-1] ? route_of(mq[i][0]) : mheld[i];
  endfunction

  initial begin
    for (int i = 0; i < NP; i++) begin
      mheld[i] = 0; mown[i] = 0; mptr[i] = 0; mlock[i] = 0;
    end
    forever begin
      @(negedge clk);
      if (gen_on) begin
        for (int i = 0; i < NP; i++) begin
          if (MASK[i]) begin
            in_valid[i] = (pend[i].size() != 0) && ($urandom % 5 != 0);
            in_data[i*FW +: FW] = (pend[i].size() != 0) ? pend[i][0] : '0;
          end else begin
            in_valid[i] = ($urandom % 3 == 0);
            in_data[i*FW +: FW] = mk(1, 1, CX, CY, 8'hEE);
          end
          out_ready[i] = ($urandom % 4 != 0);
        end
      end
      #1;
      for (int o = 0; o < NP; o++) begin
        eg[o] = -1;
        if (mlock[o]) begin
          if (want(mown[o]) == o) eg[o] = mown[o];
        end else begin
          for (int k = 0; k < NP; k++) begin
            int i;
            i = (mptr[o] + k) % NP;
            if (eg[o] < 0 && want(i) == o) eg[o] = i;
          end
        end
      end
      if (model_on) begin
        bit ok;
        ok = 1;
        for (int o = 0; o < NP; o++) begin
          if (out_valid[o] !== (eg[o] >= 0)) begin
            ok = 0;
            $display("FAIL R8 out_valid[%0d] actual=%0b expected=%0b", o, out_valid[o], eg[o] >= 0);
          end else if (eg[o] >= 0 && out_data[o*FW +: FW] !== mq[eg[o]][0]) begin
            ok = 0;
            $display("FAIL R7 out_data[%0d] actual=%0h expected=%0h", o, out_data[o*FW +: FW], mq[eg[o]][0]);
          end
          if (in_ready[o] !== (MASK[o] && mq[o].size() < 4)) begin
            ok = 0;
            $display("FAIL R9 in_ready[%0d] actual=%0b expected=%0b", o, in_ready[o], MASK[o] && mq[o].size() < 4);
          end
        end
        n_chk++;
        if (!ok) n_fail++;
      end
      @(posedge clk);
      if (model_on) begin
        bit acc [NP];
        for (int i = 0; i < NP; i++) acc[i] = in_valid[i] && MASK[i] && (mq[i].size() < 4);
        for (int o = 0; o < NP; o++) begin
          if (eg[o] >= 0) begin
            logic [FW-1:0] f;
            bit fire;
            f = mq[eg[o]][0];
            fire = out_ready[o];
            if (fire) begin
              void'(mq[eg[o]].pop_front());
              recv++;
              if (f[FW-1]) begin
                mheld[eg[o]] = route_of(f);
                mptr[o] = (eg[o] + 1) % NP;
              end
            end
            mlock[o] = !(fire && f[FW-2]);
            mown[o] = eg[o];
          end
        end
        for (int i = 0; i < NP; i++)
          if (acc[i]) begin
            mq[i].push_back(in_data[i*FW +: FW]);
            if (gen_on && pend[i].size() != 0) void'(pend[i].pop_front());
          end
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic one_flit(input int ip, input int dx, input int dy, input int exp_o, input string tag);
    logic [FW-1:0] f;
    f = mk(1, 1, dx, dy, sent & 8'hFF);
    sent++;
    @(negedge clk);
    in_valid[ip] = 1'b1;
    in_data[ip*FW +: FW] = f;
    @(negedge clk);
    in_valid[ip] = 1'b0;
    #2;
    chk(out_valid == NP'(1 << exp_o), {tag, " output select"}, out_valid, NP'(1 << exp_o));
    chk(out_data[exp_o*FW +: FW] == f, {tag, " flit"}, out_data[exp_o*FW +: FW], f);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    #2;
    // R10 reset state
    chk(out_valid == '0, "R10 reset out_valid", out_valid, 0);
    chk(in_ready == MASK, "R10 reset in_ready", in_ready, MASK);

    one_flit(0, 5, 4, 1, "R1 east");
    one_flit(4, 6, 4, 1, "R1 turn from Y-");
    one_flit(0, 0, 6, 2, "R2 west climbing");
    one_flit(0, 3, 4, 0, "R3 home");
    one_flit(0, 3, 7, 3, "R3 north");
    one_flit(0, 6, 1, 4, "R4 south-east");
    one_flit(0, 0, 0, 4, "R4 south-west");
    one_flit(3, 3, 6, 3, "R5 straight Y+");

    // R6: absent input
    @(negedge clk);
    in_valid[2] = 1'b1;
    in_data[2*FW +: FW] = mk(1, 1, 3, 4, 8'h5A);
    #2;
    chk(in_ready[2] == 1'b0, "R6 absent ready", in_ready[2], 0);
    @(negedge clk);
    in_valid[2] = 1'b0;
    #2;
    chk(out_valid == '0, "R6 absent forwards nothing", out_valid, 0);

    // R7: body flits follow the head route although their fields point south
    begin
      logic [FW-1:0] pk [3];
      pk[0] = mk(1, 0, 5, 4, 8'hA0);
      pk[1] = mk(0, 0, 3, 0, 8'hA1);
      pk[2] = mk(0, 1, 0, 0, 8'hA2);
      @(negedge clk);
      in_valid[0] = 1'b1;
      in_data[0 +: FW] = pk[0];
      for (int k = 1; k <= 3; k++) begin
        @(negedge clk);
        if (k < 3) in_data[0 +: FW] = pk[k]; else in_valid[0] = 1'b0;
        #2;
        chk(out_valid == 5'b00010, "R7 packet on X+", out_valid, 5'b00010);
        chk(out_data[FW +: FW] == pk[k-1], "R7 packet flit", out_data[FW +: FW], pk[k-1]);
      end
    end

    // R9: back-pressure fills the FIFO and holds the output
    @(negedge clk);
    out_ready[3] = 1'b0;
    in_valid[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      in_data[0 +: FW] = mk(1, 1, 3, 6, 8'hB0 + k);
      @(negedge clk);
    end
    in_valid[0] = 1'b0;
    #2;
    chk(in_ready[0] == 1'b0, "R9 full FIFO not ready", in_ready[0], 0);
    chk(out_valid[3] && out_data[3*FW +: FW] == mk(1, 1, 3, 6, 8'hB0), "R9 stalled head", out_data[3*FW +: FW], mk(1, 1, 3, 6, 8'hB0));
    @(negedge clk);
    #2;
    chk(out_valid[3] && out_data[3*FW +: FW] == mk(1, 1, 3, 6, 8'hB0), "R9 held through stall", out_data[3*FW +: FW], mk(1, 1, 3, 6, 8'hB0));
    out_ready[3] = 1'b1;
    repeat (6) @(negedge clk);

    // random legal traffic, R5 and R8 via the reference model
    for (int i = 0; i < NP; i++) begin
      if (MASK[i]) begin
        for (int p = 0; p < 40; p++) begin
          int len, dx, dy;
          len = 1 + $urandom % 3;
          case (i)
            0: begin dx = $urandom % 8;          dy = $urandom % 8; end
            1: begin dx = CX + $urandom % 5;     dy = CY + $urandom % 4; end
            3: begin dx = CX;                    dy = CY + $urandom % 4; end
            default: begin dx = $urandom % 8;    dy = $urandom % (CY + 1); end
          endcase
          for (int f = 0; f < len; f++) begin
            if (f == 0) pend[i].push_back(mk(1, len == 1, dx, dy, $urandom));
            else pend[i].push_back(mk(0, f == len - 1, $urandom, $urandom, $urandom));
          end
        end
      end
    end
    gen_on = 1;
    while ((pend[0].size() + pend[1].size() + pend[3].size() + pend[4].size()) != 0 && cycles < 20000)
      @(negedge clk);
    gen_on = 0;
    @(negedge clk);
    in_valid = '0;
    out_ready = '1;
    while ((mq[0].size() + mq[1].size() + mq[3].size() + mq[4].size()) != 0 && cycles < 20000)
      @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    chk(out_valid == '0, "R8 all traffic drained", out_valid, 0);
    if (cycles >= 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected<%0d", cycles, 20000);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) cycles <= cycles + 1;
endmodule